// File: doc/BRIEF.md
# Barrel Shifter with Carry and Status Merge

This block shifts a 32-bit operand by up to 31 places in one of three ways: logical right, arithmetic right or logical left. It is purely combinational. The result and the flags settle in the same cycle as the inputs. The shift count comes from one of two sources. The first is a 5-bit immediate, which is zero-extended. The second is the least significant bits of a register value.

The shifter also reports flags and folds them into a status word:

- **Zero:** set when the result is zero.
- **Sign:** a copy of result bit 31.
- **Carry:** the last bit that left the operand. It is zero when nothing moved.
- **Overflow:** always cleared.

Every other status bit, including the sticky saturation bit, passes through unchanged. The block sits beside the ALU in an execute stage. The surrounding decode logic picks the direction, the fill mode and the count source.

Top module: `shifter_cy`

## Requirements
- R1: The shift count is `reg_amt[4:0]` when `use_reg` is 1, and `imm_amt` when `use_reg` is 0. Bits 31:5 of `reg_amt` have no effect, and the unselected source has no effect.
- R2: When `shift_left`=0 and `arith`=0, the result is the operand moved right by the count, with zeros filling the vacated top bits.
- R3: When `shift_left`=0 and `arith`=1, the result is the operand moved right by the count, with the operand's original bit 31 filling the vacated top bits.
- R4: When `shift_left`=1, the result is the operand moved left by the count with zero fill. In this mode `arith` has no effect.
- R5: For a right shift with a count n of 1 to 31, carry (status bit 3) equals operand bit n-1.
- R6: For a left shift with a count n of 1 to 31, carry (status bit 3) equals operand bit 32-n.
- R7: A count of zero returns the operand unchanged and clears carry, in every mode.
- R8: Status bit 0 (zero) is 1 exactly when the result is zero. Status bit 1 (sign) equals result bit 31.
- R9: Status bit 2 (overflow) is 0 after every shift.
- R10: Status bits other than 0 to 3 pass from `status_in` to `status_out` unchanged. This includes the saturation bit at position 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 32 | Value to be shifted |
| imm_amt | input | 5 | Immediate shift count, zero-extended |
| reg_amt | input | 32 | Register value; only its low 5 bits are used as the count |
| use_reg | input | 1 | 1 selects `reg_amt[4:0]`, 0 selects `imm_amt` |
| shift_left | input | 1 | 1 shifts left, 0 shifts right |
| arith | input | 1 | For right shifts, 1 selects sign fill and 0 selects zero fill |
| status_in | input | 8 | Current status word |
| result | output | 32 | Shifted value |
| status_out | output | 8 | Status word with zero, sign, overflow and carry replaced |

## Verification
The bench sweeps every count from 0 to 31 in all four direction and fill combinations and from both count sources. The operands include all-zeros, all-ones, a lone sign bit, a lone low bit and pseudo-random words.

- **Count of zero:** a design that indexed bit -1 or bit 32 for carry would report a stray carry at zero, or corrupt the result there.
- **Top bits of `reg_amt`:** these are loaded with garbage. A decoder that used too many bits would then shift by the wrong amount.
- **Negative operands:** these separate sign fill from zero fill. They also expose a left shift that wrongly took notice of `arith`.
- **Status passthrough:** random `status_in` values show whether the saturation bit or any spare bit was disturbed, or whether overflow leaked through.

// File: rtl/shifter_cy.sv
module shifter_cy #(
  parameter int W      = 32,
  parameter int SW     = 8,
  parameter int Z_BIT  = 0,
  parameter int S_BIT  = 1,
  parameter int OV_BIT = 2,
  parameter int CY_BIT = 3,
  localparam int AW    = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] imm_amt,
  input  logic [W-1:0]  reg_amt,
  input  logic          use_reg,
  input  logic          shift_left,
  input  logic          arith,
  input  logic [SW-1:0] status_in,
  output logic [W-1:0]  result,
  output logic [SW-1:0] status_out
);

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) flip[i] = v[W-1-i];
  endfunction

  logic [AW-1:0] amt;
  logic [AW-1:0] amt_m1;
  logic [W-1:0]  src;
  logic [W-1:0]  right;
  logic          fill;
  logic          cy;
  logic [W-1:0]  stg [0:AW];

  assign amt    = use_reg ? reg_amt[AW-1:0] : imm_amt;
  assign amt_m1 = amt - 1'b1;
  assign src    = shift_left ? flip(operand) : operand;
  assign fill   = ~shift_left & arith & operand[W-1];
  assign stg[0] = src;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][W-1:SH]} : stg[k];
  end

  assign right  = stg[AW];
  assign result = shift_left ? flip(right) : right;
  assign cy     = (amt != '0) & src[amt_m1];

  always_comb begin
    status_out         = status_in;
    status_out[Z_BIT]  = ~|result;
    status_out[S_BIT]  = result[W-1];
    status_out[OV_BIT] = 1'b0;
    status_out[CY_BIT] = cy;
  end

endmodule

// File: rtl/shifter_cy_chk.sv
module shifter_cy_chk #(
  parameter int W      = 32,
  parameter int SW     = 8,
  parameter int Z_BIT  = 0,
  parameter int S_BIT  = 1,
  parameter int OV_BIT = 2,
  parameter int CY_BIT = 3,
  localparam int AW    = $clog2(W)
) (
  input logic [W-1:0]  operand,
  input logic [AW-1:0] imm_amt,
  input logic [W-1:0]  reg_amt,
  input logic          use_reg,
  input logic          shift_left,
  input logic          arith,
  input logic [SW-1:0] status_in,
  input logic [W-1:0]  result,
  input logic [SW-1:0] status_out
);

  logic [AW-1:0] n;
  assign n = use_reg ? reg_amt[AW-1:0] : imm_amt;

  always_comb begin
    // R7
    zero_count_chk: assert (n != '0 || (result == operand && !status_out[CY_BIT]))
      else $error("zero count altered operand or carry");
    // R9
    no_overflow_chk: assert (!status_out[OV_BIT])
      else $error("overflow not cleared");
    // R8
    zero_flag_chk: assert ((result == '0) == status_out[Z_BIT])
      else $error("zero flag mismatch");
    // R8
    sign_flag_chk: assert (status_out[S_BIT] == result[W-1])
      else $error("sign flag mismatch");
    // R3
    sign_fill_chk: assert (shift_left || !arith || n == '0 || result[W-1] == operand[W-1])
      else $error("arithmetic fill wrong");
    // R2
    zero_fill_chk: assert (shift_left || arith || n == '0 || !result[W-1])
      else $error("logical right fill wrong");
    // R4
    left_fill_chk: assert (!shift_left || n == '0 || !result[0])
      else $error("left fill wrong");
    // R5
    right_carry_chk: assert (shift_left || n == '0 || status_out[CY_BIT] == operand[n-1'b1])
      else $error("right carry wrong");
  end

  for (genvar b = 0; b < SW; b++) begin : g_pass
    if (b != Z_BIT && b != S_BIT && b != OV_BIT && b != CY_BIT) begin : g_keep
      always_comb begin
        // R10
        status_pass_chk: assert (status_out[b] == status_in[b])
          else $error("status bit %0d disturbed", b);
      end
    end
  end

endmodule

bind shifter_cy shifter_cy_chk #(
  .W(W), .SW(SW), .Z_BIT(Z_BIT), .S_BIT(S_BIT), .OV_BIT(OV_BIT), .CY_BIT(CY_BIT)
) i_chk (.*);

// File: tb/test_shifter_cy.sv
module test_shifter_cy;
  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] operand, reg_amt, result;
  logic [4:0]  imm_amt;
  logic        use_reg, shift_left, arith;
  logic [7:0]  status_in, status_out;

  shifter_cy i_shifter_cy (
    .operand(operand), .imm_amt(imm_amt), .reg_amt(reg_amt), .use_reg(use_reg),
    .shift_left(shift_left), .arith(arith), .status_in(status_in),
    .result(result), .status_out(status_out)
  );

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [31:0] rng = 32'h1234_5679;

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (op=%h n=%0d L=%0b A=%0b reg=%0b)",
               tag, got, exp, operand, use_reg ? reg_amt[4:0] : imm_amt,
               shift_left, arith, use_reg);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] ops [12];
    logic [31:0] er;
    logic        ecy;
    string       tag;
    ops[0] = 32'h0000_0000;
    ops[1] = 32'hFFFF_FFFF;
    ops[2] = 32'h8000_0000;
    ops[3] = 32'h0000_0001;
    for (int i = 4; i < 12; i++) begin
      rng = nxt(rng);
      ops[i] = rng;
    end
    for (int m = 0; m < 4; m++) begin
      for (int src = 0; src < 2; src++) begin
        for (int n = 0; n < 32; n++) begin
          for (int o = 0; o < 12; o++) begin
            @(posedge clk);
            rng = nxt(rng);
            shift_left = m[1];
            arith      = m[0];
            use_reg    = src[0];
            operand    = ops[o];
            status_in  = rng[7:0];
            if (src == 1) begin
              reg_amt = {rng[31:5], 5'(n)};
              imm_amt = ~5'(n);
            end else begin
              reg_amt = {rng[26:0], ~5'(n)};
              imm_amt = 5'(n);
            end
            @(negedge clk);
            if (m[1]) er = operand << n;
            else if (m[0]) er = $unsigned($signed(operand) >>> n);
            else er = operand >> n;
            if (n == 0) ecy = 1'b0;
            else if (m[1]) ecy = operand[32-n];
            else ecy = operand[n-1];
            if (n == 0) tag = "R7 result";
            else if (m[1]) tag = "R4 left result";
            else if (m[0]) tag = "R3 arith result";
            else tag = "R2 logical result";
            if (src == 1) tag = {tag, " R1 reg count"};
            else tag = {tag, " R1 imm count"};
            chk(tag, result, er);
            if (n == 0) tag = "R7 carry";
            else if (m[1]) tag = "R6 carry";
            else tag = "R5 carry";
            chk(tag, {31'd0, status_out[3]}, {31'd0, ecy});
            chk("R8 zero flag", {31'd0, status_out[0]}, {31'd0, er == 32'd0});
            chk("R8 sign flag", {31'd0, status_out[1]}, {31'd0, er[31]});
            chk("R9 overflow", {31'd0, status_out[2]}, 32'd0);
            chk("R10 passthrough", {24'd0, status_out[7:4], 4'd0},
                {24'd0, status_in[7:4], 4'd0});
          end
        end
      end
    end
    done = 1'b1;
    summary();
  end
endmodule